// File: doc/BRIEF.md
# Transmit Jabber and Heartbeat Supervisor

This block sits beside the transmit side of a 10 Mb/s media-independent interface and watches the transmit enable. If the enable stays high for longer than the jabber limit, it closes the transmit gate, raises a jabber indication, and holds the collision line high. The gate reopens only after the enable has stayed low for a much longer quiet interval. A read-to-clear sticky bit records each jabber entry, so software still sees an event that is already over.

In half-duplex operation the block also produces the signal quality (heartbeat) test. After each frame ends, it waits a fixed delay and then drives a short pulse on the collision line. The pulse is suppressed in full-duplex mode, or when the heartbeat enable is low. All intervals are parameters counted in reference clock cycles. The defaults assume a 50 MHz clock: 85 ms jabber limit, 500 ms quiet interval, 1.2 us heartbeat delay and 1 us pulse width.

Top module: `tx_jabber_sup`

## Requirements
- R1: After reset, jabber_o, jab_flag_o and col_o are 0, and no jabber or heartbeat timer is running.
- R2: While not in jabber, tx_gate_o equals tx_en_i. On the JAB_CYCLES-th consecutive rising clock edge that samples tx_en_i high, the block enters jabber: jabber_o goes to 1 and tx_gate_o goes to 0.
- R3: Any edge that samples tx_en_i low restarts the jabber count from zero. A frame that is high for JAB_CYCLES-1 edges causes no jabber.
- R4: In jabber, tx_gate_o stays 0 whatever tx_en_i does. Jabber ends on the UNJAB_CYCLES-th consecutive edge that samples tx_en_i low.
- R5: An edge that samples tx_en_i high during jabber restarts the quiet count from zero.
- R6: col_o is 1 for every cycle in which jabber_o is 1.
- R7: A frame end is the first edge that samples tx_en_i low after an edge that sampled it high, while not in jabber. On the HB_DELAY-th edge after a frame end, col_o rises and stays high for HB_WIDTH cycles.
- R8: No heartbeat pulse is produced, and a pending one is dropped, while full_duplex_i is 1 or hb_en_i is 0.
- R9: jab_flag_o is set on the edge that enters jabber. It is cleared on an edge with status_rd_i high, unless that same edge enters jabber.
- R10: A new frame end while a heartbeat is pending restarts the delay, timed from the new frame end.
- R11: Leaving jabber produces no heartbeat pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| full_duplex_i | input | 1 | 1 selects full-duplex operation |
| hb_en_i | input | 1 | 1 enables the heartbeat pulse |
| status_rd_i | input | 1 | Read strobe that clears the sticky jabber bit |
| tx_gate_o | output | 1 | Transmit enable passed on to the line side |
| jabber_o | output | 1 | Live jabber state |
| jab_flag_o | output | 1 | Sticky jabber event bit |
| col_o | output | 1 | Collision line (heartbeat or jabber) |

## Verification
The hardest condition to reach is the end of jabber, because it needs a long run of quiet cycles with exact counts. The bench overrides the intervals with small values. It then holds the enable low for one cycle short of the quiet interval, with a single high cycle inserted part way through. This shows that the count restarts, and that the exit happens on the exact edge that follows. Retriggering the heartbeat is reached by ending a second frame while the first pulse is still pending. The bench then checks that the collision line stays low past the point where the first pulse would have started.

// File: rtl/jhb_pkg.sv
package jhb_pkg;
  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_e;
endpackage

// File: rtl/jhb_jabber.sv
module jhb_jabber #(
  parameter int unsigned JAB_CYCLES   = 4_250_000,
  parameter int unsigned UNJAB_CYCLES = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  output logic jabbed_o,
  output logic jab_set_o
);
  localparam int unsigned JW = $clog2(JAB_CYCLES);
  localparam int unsigned UW = $clog2(UNJAB_CYCLES);
  localparam logic [JW-1:0] JAB_LAST   = JW'(JAB_CYCLES - 1);
  localparam logic [UW-1:0] UNJAB_LAST = UW'(UNJAB_CYCLES - 1);

  logic          jab_q;
  logic [JW-1:0] on_cnt_q;
  logic [UW-1:0] off_cnt_q;
  logic          unjab;

  assign jab_set_o = tx_en_i && !jab_q && (on_cnt_q == JAB_LAST);
  assign unjab     = jab_q && !tx_en_i && (off_cnt_q == UNJAB_LAST);
  assign jabbed_o  = jab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      jab_q     <= 1'b0;
      on_cnt_q  <= '0;
      off_cnt_q <= '0;
    end else if (!jab_q) begin
      off_cnt_q <= '0;
      if (!tx_en_i) begin
        on_cnt_q <= '0;
      end else if (jab_set_o) begin
        jab_q    <= 1'b1;
        on_cnt_q <= '0;
      end else begin
        on_cnt_q <= on_cnt_q + 1'b1;
      end
    end else begin
      on_cnt_q <= '0;
      if (tx_en_i) begin
        off_cnt_q <= '0;          // any activity restarts the quiet interval
      end else if (unjab) begin
        jab_q     <= 1'b0;
        off_cnt_q <= '0;
      end else begin
        off_cnt_q <= off_cnt_q + 1'b1;
      end
    end
  end

  assert_jab_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jab_q) |-> $past(tx_en_i));
  assert_unjab_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(jab_q) |-> !$past(tx_en_i));
endmodule

// File: rtl/jhb_heartbeat.sv
module jhb_heartbeat
  import jhb_pkg::*;
#(
  parameter int unsigned HB_DELAY = 60,
  parameter int unsigned HB_WIDTH = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic jabbed_i,
  input  logic full_duplex_i,
  input  logic hb_en_i,
  output logic pulse_o
);
  localparam int unsigned HB_MAX = (HB_DELAY > HB_WIDTH) ? HB_DELAY : HB_WIDTH;
  localparam int unsigned HW = $clog2(HB_MAX);
  localparam logic [HW-1:0] DLY_LAST = HW'(HB_DELAY - 1);
  localparam logic [HW-1:0] WID_LAST = HW'(HB_WIDTH - 1);

  hb_state_e     st_q;
  logic [HW-1:0] cnt_q;
  logic          en_d_q;
  logic          allowed;
  logic          frame_end;

  assign allowed   = hb_en_i && !full_duplex_i && !jabbed_i;
  assign frame_end = en_d_q && !tx_en_i && !jabbed_i;
  assign pulse_o   = (st_q == HB_PULSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= HB_IDLE;
      cnt_q  <= '0;
      en_d_q <= 1'b0;
    end else begin
      en_d_q <= tx_en_i;
      if (!allowed) begin
        st_q  <= HB_IDLE;
        cnt_q <= '0;
      end else if (frame_end) begin
        st_q  <= HB_WAIT;       // restart delay on each frame end
        cnt_q <= '0;
      end else begin
        unique case (st_q)
          HB_WAIT: begin
            if (cnt_q == DLY_LAST) begin
              st_q  <= HB_PULSE;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          HB_PULSE: begin
            if (cnt_q == WID_LAST) begin
              st_q  <= HB_IDLE;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
            st_q  <= HB_IDLE;
            cnt_q <= '0;
          end
        endcase
      end
    end
  end

  assert_hb_allowed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != HB_IDLE) |-> $past(hb_en_i && !full_duplex_i));
  assert_hb_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == HB_PULSE) |-> (cnt_q <= WID_LAST));
endmodule

// File: rtl/tx_jabber_sup.sv
module tx_jabber_sup #(
  parameter int unsigned JAB_CYCLES   = 4_250_000,
  parameter int unsigned UNJAB_CYCLES = 25_000_000,
  parameter int unsigned HB_DELAY     = 60,
  parameter int unsigned HB_WIDTH     = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic full_duplex_i,
  input  logic hb_en_i,
  input  logic status_rd_i,
  output logic tx_gate_o,
  output logic jabber_o,
  output logic jab_flag_o,
  output logic col_o
);
  logic jabbed;
  logic jab_set;
  logic hb_pulse;
  logic flag_q;

  jhb_jabber #(
    .JAB_CYCLES  (JAB_CYCLES),
    .UNJAB_CYCLES(UNJAB_CYCLES)
  ) u_jabber (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tx_en_i  (tx_en_i),
    .jabbed_o (jabbed),
    .jab_set_o(jab_set)
  );

  jhb_heartbeat #(
    .HB_DELAY(HB_DELAY),
    .HB_WIDTH(HB_WIDTH)
  ) u_heartbeat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tx_en_i      (tx_en_i),
    .jabbed_i     (jabbed),
    .full_duplex_i(full_duplex_i),
    .hb_en_i      (hb_en_i),
    .pulse_o      (hb_pulse)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_q <= 1'b0;
    else if (jab_set)     flag_q <= 1'b1;   // set beats clear
    else if (status_rd_i) flag_q <= 1'b0;
  end

  assign tx_gate_o  = tx_en_i && !jabbed;
  assign jabber_o   = jabbed;
  assign jab_flag_o = flag_q;
  assign col_o      = jabbed || hb_pulse;

  assert_flag_on_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jabbed) |-> flag_q);
  assert_no_col_fdx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_duplex_i && $past(full_duplex_i) && !jabbed) |-> !col_o);
endmodule

// File: tb/sim_tx_jabber_sup.sv
module sim_tx_jabber_sup;
  localparam int unsigned JAB   = 20;
  localparam int unsigned UNJAB = 30;
  localparam int unsigned HBD   = 6;
  localparam int unsigned HBW   = 4;
  localparam int unsigned NV    = 31;

  // {tx_en, fdx, hb_en, rd, exp_gate, exp_col, exp_jab, exp_flag}
  localparam logic [7:0] VEC [NV] = '{
    8'b1010_1000, 8'b1010_1000, 8'b0010_0000, 8'b0010_0000, // R7 frame end
    8'b0010_0000, 8'b0010_0000, 8'b0010_0000, 8'b0010_0000,
    8'b0010_0100, 8'b0010_0100, 8'b0010_0100, 8'b0010_0100, // pulse
    8'b0010_0000,
    8'b1110_1000, 8'b0110_0000, 8'b0110_0000, 8'b0110_0000, // R8 full duplex
    8'b0110_0000, 8'b0110_0000, 8'b0110_0000, 8'b0110_0000,
    8'b0110_0000,
    8'b1000_1000, 8'b0000_0000, 8'b0000_0000, 8'b0000_0000, // R8 hb disabled
    8'b0000_0000, 8'b0000_0000, 8'b0000_0000, 8'b0000_0000,
    8'b0000_0000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, fdx = 1'b0, hb_en = 1'b1, rd = 1'b0;
  logic gate, jab, flag, col;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tx_jabber_sup #(
    .JAB_CYCLES(JAB), .UNJAB_CYCLES(UNJAB), .HB_DELAY(HBD), .HB_WIDTH(HBW)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .full_duplex_i(fdx),
    .hb_en_i(hb_en), .status_rd_i(rd), .tx_gate_o(gate), .jabber_o(jab),
    .jab_flag_o(flag), .col_o(col)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic step(input logic e, input logic f, input logic h, input logic r);
    tx_en = e; fdx = f; hb_en = h; rd = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "jabber", jab, 1'b0);
    chk("R1", "flag", flag, 1'b0);
    chk("R1", "col", col, 1'b0);

    // R7, R8 table
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      chk(VEC[i][6] || !VEC[i][5] ? "R8" : "R7", "gate", gate, VEC[i][3]);
      chk(VEC[i][6] || !VEC[i][5] ? "R8" : "R7", "col",  col,  VEC[i][2]);
      chk("R2", "jabber", jab, VEC[i][1]);
      chk("R9", "flag", flag, VEC[i][0]);
    end

    // R3: one edge short of the limit
    repeat (JAB - 1) step(1, 0, 1, 0);
    chk("R3", "jabber", jab, 1'b0);
    chk("R3", "gate", gate, 1'b1);
    step(0, 0, 1, 0);
    chk("R3", "jabber after frame", jab, 1'b0);
    repeat (12) step(0, 0, 1, 0);

    // R2, R6, R9 jabber entry
    repeat (JAB - 1) step(1, 0, 1, 0);
    chk("R2", "jabber before limit", jab, 1'b0);
    step(1, 0, 1, 0);
    chk("R2", "jabber at limit", jab, 1'b1);
    chk("R2", "gate closed", gate, 1'b0);
    chk("R6", "col in jabber", col, 1'b1);
    chk("R9", "flag set", flag, 1'b1);
    step(1, 0, 1, 1);
    chk("R9", "flag cleared by read", flag, 1'b0);
    chk("R9", "jabber kept", jab, 1'b1);

    // R4, R5 unjab with restart
    repeat (25) step(0, 0, 1, 0);
    chk("R4", "still jabber", jab, 1'b1);
    chk("R6", "col held", col, 1'b1);
    step(1, 0, 1, 0);
    chk("R4", "gate stays closed", gate, 1'b0);
    repeat (UNJAB - 1) step(0, 0, 1, 0);
    chk("R5", "count restarted", jab, 1'b1);
    step(0, 0, 1, 0);
    chk("R4", "jabber left", jab, 1'b0);
    chk("R6", "col released", col, 1'b0);
    for (int k = 0; k < 8; k++) begin
      step(0, 0, 1, 0);
      chk("R11", "no heartbeat on unjab", col, 1'b0);
    end
    step(1, 0, 1, 0);
    chk("R4", "gate reopened", gate, 1'b1);

    // R10 retrigger
    step(1, 0, 1, 0);
    step(0, 0, 1, 0);
    repeat (3) step(0, 0, 1, 0);
    step(1, 0, 1, 0);
    step(0, 0, 1, 0);
    for (int k = 0; k < HBD - 1; k++) begin
      step(0, 0, 1, 0);
      chk("R10", "delay restarted", col, 1'b0);
    end
    step(0, 0, 1, 0);
    chk("R10", "pulse after new frame end", col, 1'b1);

    finish_run();
  end
endmodule